// File: doc/BRIEF.md
# Panel Serial Register Initialiser

This block programs the control registers of a display panel over a three-wire serial link made of an active-low select line, a clock and a data line. Each transfer carries an 8-bit register address followed by an 8-bit value. The panel captures data on the rising clock edge. A built-in sequencer can send a fixed power-up list of five writes or a single power-down write. Logic outside the block can also ask for one write with an address and value of its choosing.

The serial bit rate comes from a one-cycle rate-enable input. Every edge of the serial lines waits for a rate tick, so the wires never move faster than that tick allows. The block raises `busy` while a job is in progress. When the last frame of a job has finished and the select line has been idle for the required gap, the block pulses `done` for one cycle. A request that arrives while the block is busy is dropped without any effect.

Top module: `panel_sreg_init`

## Requirements
- R1: Each frame shifts out 16 bits, most significant first. Bits 15:8 hold the register address and bits 7:0 hold the value.
- R2: While no frame is in progress, `ser_sel_n` and `ser_clk` are high and `ser_dat` is low. `ser_sel_n` falls only while `ser_clk` is high and `ser_dat` is low.
- R3: For each bit, `ser_clk` falls and `ser_dat` takes the new bit in the same cycle, and `ser_clk` rises on a later tick. `ser_dat` does not change while `ser_clk` is high and the select line is low.
- R4: `ser_sel_n` returns high after exactly 16 rising clock edges, with `ser_clk` high at that moment.
- R5: A power-up request sends, in this order: (0x05,0x1E), (0x05,0x5E), (0x07,0x8D), (0x13,0x01), (0x05,0x5F).
- R6: A power-down request sends the single frame (0x05,0x5E).
- R7: A single-write request sends one frame carrying `wr_addr` and `wr_data`, as they were when the request was taken.
- R8: The serial lines change only on a cycle that follows a rate tick. `ser_sel_n` stays high for at least GAP_TICKS ticks (default 2) between frames.
- R9: `busy` rises in the cycle after a request is accepted and stays high until the job ends. Any request made while `busy` is high produces no frame and does not change the job.
- R10: `done` is high for exactly one cycle. That cycle comes after the last frame's select gap, and `busy` goes low in the same cycle.
- R11: If more than one request is made in the same idle cycle, power-up wins over power-down, and power-down wins over single-write.
- R12: After reset, `ser_sel_n`=1, `ser_clk`=1, `ser_dat`=0, `busy`=0 and `done`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rate_tick | input | 1 | One-cycle enable that paces the serial lines |
| req_power_up | input | 1 | Start the five-write power-up list |
| req_power_down | input | 1 | Start the power-down write |
| req_write | input | 1 | Start a single write |
| wr_addr | input | 8 | Register address for a single write |
| wr_data | input | 8 | Value for a single write |
| busy | output | 1 | Job in progress; requests are ignored |
| done | output | 1 | One-cycle pulse at the end of a job |
| ser_sel_n | output | 1 | Serial select, active low |
| ser_clk | output | 1 | Serial clock; the panel samples on the rising edge |
| ser_dat | output | 1 | Serial data |

## Verification
Two events can share a cycle: the `done` pulse that closes one job and the acceptance of the next request. `busy` is already low in the `done` cycle, so the bench issues a new request exactly when it sees `done` and expects that request to start a job. The bench also issues requests earlier, in cycles where its model still counts the block as busy, and expects those to be dropped. The reference model decodes every frame from the wires and predicts `busy` and `done` cycle by cycle. It follows the order of the select gap, the end of the frame and the acceptance of a request, so a one-cycle slip in the handover shows up as a mismatch on `busy`, on `done` or on the frame list.

// File: rtl/panel_sreg_pkg.sv
package panel_sreg_pkg;

   localparam int ADDR_W  = 8;
   localparam int VAL_W   = 8;
   localparam int FRAME_W = ADDR_W + VAL_W;
   localparam int SIDX_W  = 3;

   // script slots: power-up list occupies 0..4, power-down sits at 5
   localparam logic [SIDX_W-1:0] UP_FIRST = 3'd0;
   localparam logic [SIDX_W-1:0] UP_LAST  = 3'd4;
   localparam logic [SIDX_W-1:0] DOWN_IDX = 3'd5;

   typedef logic [FRAME_W-1:0] frame_t;

   typedef enum logic [2:0] {
      SH_IDLE,
      SH_ARM,
      SH_LOW,
      SH_HIGH,
      SH_TAIL,
      SH_GAP
   } sh_state_t;

   typedef enum logic {
      SQ_IDLE,
      SQ_RUN
   } sq_state_t;

   function automatic frame_t script_frame(input logic [SIDX_W-1:0] slot);
      frame_t f;
      case (slot)
         3'd0:    f = {8'h05, 8'h1E};
         3'd1:    f = {8'h05, 8'h5E};
         3'd2:    f = {8'h07, 8'h8D};
         3'd3:    f = {8'h13, 8'h01};
         3'd4:    f = {8'h05, 8'h5F};
         3'd5:    f = {8'h05, 8'h5E};
         default: f = '0;
      endcase
      return f;
   endfunction

endpackage

// File: rtl/panel_sreg_shift.sv
module panel_sreg_shift
   import panel_sreg_pkg::*;
#(
   parameter int PHASE_TICKS = 1,
   parameter int GAP_TICKS   = 2
) (
   input  logic   clk,
   input  logic   rst_n,
   input  logic   tick,
   input  logic   load,
   input  frame_t frame,
   output logic   ready,
   output logic   frame_done,
   output logic   ser_sel_n,
   output logic   ser_clk,
   output logic   ser_dat
);

   localparam int BIT_W = $clog2(FRAME_W);
   localparam int GAP_W = (GAP_TICKS > 1) ? $clog2(GAP_TICKS) : 1;
   localparam int PC_W  = (PHASE_TICKS > 1) ? $clog2(PHASE_TICKS) : 1;

   sh_state_t         st;
   frame_t            shreg;
   logic [BIT_W-1:0]  bitn;
   logic [GAP_W-1:0]  gapn;
   logic              step;

   // phase pacing: either every tick, or every PHASE_TICKS ticks
   generate
      if (PHASE_TICKS == 1) begin : g_step_direct
         assign step = tick;
      end else begin : g_step_div
         logic [PC_W-1:0] pc;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               pc <= '0;
            else if (st == SH_IDLE)
               pc <= '0;
            else if (tick)
               pc <= (pc == PC_W'(PHASE_TICKS - 1)) ? '0 : pc + 1'b1;
         end
         assign step = tick && (pc == PC_W'(PHASE_TICKS - 1));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st         <= SH_IDLE;
         shreg      <= '0;
         bitn       <= '0;
         gapn       <= '0;
         ser_sel_n  <= 1'b1;
         ser_clk    <= 1'b1;
         ser_dat    <= 1'b0;
         frame_done <= 1'b0;
      end else begin
         frame_done <= 1'b0;
         case (st)
            SH_IDLE: begin
               if (load) begin
                  shreg <= frame;
                  st    <= SH_ARM;
               end
            end
            SH_ARM: begin
               if (step) begin
                  ser_sel_n <= 1'b0;
                  bitn      <= '0;
                  st        <= SH_LOW;
               end
            end
            SH_LOW: begin
               if (step) begin
                  ser_clk <= 1'b0;
                  ser_dat <= shreg[FRAME_W-1];
                  shreg   <= {shreg[FRAME_W-2:0], 1'b0};
                  st      <= SH_HIGH;
               end
            end
            SH_HIGH: begin
               if (step) begin
                  ser_clk <= 1'b1;
                  if (bitn == BIT_W'(FRAME_W - 1))
                     st <= SH_TAIL;
                  else begin
                     bitn <= bitn + 1'b1;
                     st   <= SH_LOW;
                  end
               end
            end
            SH_TAIL: begin
               if (step) begin
                  ser_sel_n <= 1'b1;
                  ser_dat   <= 1'b0;
                  gapn      <= '0;
                  st        <= SH_GAP;
               end
            end
            SH_GAP: begin
               if (step) begin
                  if (gapn == GAP_W'(GAP_TICKS - 1)) begin
                     st         <= SH_IDLE;
                     frame_done <= 1'b1;
                  end else
                     gapn <= gapn + 1'b1;
               end
            end
            default: st <= SH_IDLE;
         endcase
      end
   end

   assign ready = (st == SH_IDLE);

   a_r2_sel_falls_idle_lines: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ser_sel_n) |-> (ser_clk && !ser_dat));

   a_r3_dat_held_clk_high: assert property (@(posedge clk) disable iff (!rst_n)
      (ser_clk && $past(ser_clk) && !ser_sel_n && !$past(ser_sel_n)) |-> $stable(ser_dat));

   a_r4_sel_rises_clk_high: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ser_sel_n) |-> ser_clk);

   a_r8_lines_move_on_step: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable({ser_sel_n, ser_clk, ser_dat}) |-> $past(step));

endmodule

// File: rtl/panel_sreg_seq.sv
module panel_sreg_seq
   import panel_sreg_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_up,
   input  logic              req_down,
   input  logic              req_wr,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [VAL_W-1:0]  wr_data,
   input  logic              sh_ready,
   input  logic              sh_frame_done,
   output logic              frame_valid,
   output frame_t            frame,
   output logic              busy,
   output logic              done
);

   sq_state_t          st;
   logic [SIDX_W-1:0]  idx;
   logic [SIDX_W-1:0]  last;
   logic               use_user;
   logic               pend;
   logic [ADDR_W-1:0]  u_addr;
   logic [VAL_W-1:0]   u_val;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= SQ_IDLE;
         idx      <= '0;
         last     <= '0;
         use_user <= 1'b0;
         pend     <= 1'b0;
         u_addr   <= '0;
         u_val    <= '0;
         done     <= 1'b0;
      end else begin
         done <= 1'b0;
         case (st)
            SQ_IDLE: begin
               // fixed priority among simultaneous requests
               if (req_up) begin
                  st <= SQ_RUN; idx <= UP_FIRST; last <= UP_LAST;
                  use_user <= 1'b0; pend <= 1'b1;
               end else if (req_down) begin
                  st <= SQ_RUN; idx <= DOWN_IDX; last <= DOWN_IDX;
                  use_user <= 1'b0; pend <= 1'b1;
               end else if (req_wr) begin
                  st <= SQ_RUN; idx <= '0; last <= '0;
                  use_user <= 1'b1; pend <= 1'b1;
                  u_addr <= wr_addr; u_val <= wr_data;
               end
            end
            SQ_RUN: begin
               if (pend && sh_ready)
                  pend <= 1'b0;
               if (sh_frame_done) begin
                  if (idx == last) begin
                     st   <= SQ_IDLE;
                     done <= 1'b1;
                  end else begin
                     idx  <= idx + 1'b1;
                     pend <= 1'b1;
                  end
               end
            end
            default: st <= SQ_IDLE;
         endcase
      end
   end

   assign busy        = (st == SQ_RUN);
   assign frame_valid = busy && pend;
   assign frame       = use_user ? {u_addr, u_val} : script_frame(idx);

   a_r9_busy_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(req_up || req_down || req_wr));

   a_r9_busy_held_mid_job: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !sh_frame_done) |=> busy);

   a_r10_done_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r10_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && $past(busy)));

endmodule

// File: rtl/panel_sreg_init.sv
module panel_sreg_init
   import panel_sreg_pkg::*;
#(
   parameter int PHASE_TICKS = 1,
   parameter int GAP_TICKS   = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       rate_tick,
   input  logic       req_power_up,
   input  logic       req_power_down,
   input  logic       req_write,
   input  logic [7:0] wr_addr,
   input  logic [7:0] wr_data,
   output logic       busy,
   output logic       done,
   output logic       ser_sel_n,
   output logic       ser_clk,
   output logic       ser_dat
);

   generate
      if (PHASE_TICKS < 1) begin : g_bad_phase
         $error("PHASE_TICKS must be at least 1");
      end
      if (GAP_TICKS < 2) begin : g_bad_gap
         $error("GAP_TICKS must be at least 2");
      end
      if (ADDR_W != 8 || VAL_W != 8) begin : g_bad_frame
         $error("frame fields must be 8 bits each");
      end
   endgenerate

   logic   sh_ready;
   logic   sh_frame_done;
   logic   frame_valid;
   frame_t frame;

   panel_sreg_seq u_seq (
      .clk           (clk),
      .rst_n         (rst_n),
      .req_up        (req_power_up),
      .req_down      (req_power_down),
      .req_wr        (req_write),
      .wr_addr       (wr_addr),
      .wr_data       (wr_data),
      .sh_ready      (sh_ready),
      .sh_frame_done (sh_frame_done),
      .frame_valid   (frame_valid),
      .frame         (frame),
      .busy          (busy),
      .done          (done)
   );

   panel_sreg_shift #(
      .PHASE_TICKS (PHASE_TICKS),
      .GAP_TICKS   (GAP_TICKS)
   ) u_shift (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick       (rate_tick),
      .load       (frame_valid && sh_ready),
      .frame      (frame),
      .ready      (sh_ready),
      .frame_done (sh_frame_done),
      .ser_sel_n  (ser_sel_n),
      .ser_clk    (ser_clk),
      .ser_dat    (ser_dat)
   );

endmodule

// File: tb/panel_sreg_init_test.sv
`timescale 1ns/1ps
module panel_sreg_init_test;

   localparam int GAP = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic rate_tick = 1'b0;
   logic req_power_up = 1'b0, req_power_down = 1'b0, req_write = 1'b0;
   logic [7:0] wr_addr = 8'h00, wr_data = 8'h00;
   logic busy, done, ser_sel_n, ser_clk, ser_dat;

   always #2 clk = ~clk;

   panel_sreg_init uut (
      .clk(clk), .rst_n(rst_n), .rate_tick(rate_tick),
      .req_power_up(req_power_up), .req_power_down(req_power_down),
      .req_write(req_write), .wr_addr(wr_addr), .wr_data(wr_data),
      .busy(busy), .done(done),
      .ser_sel_n(ser_sel_n), .ser_clk(ser_clk), .ser_dat(ser_dat)
   );

   int n_vec = 0;
   int n_bad = 0;
   bit finished = 0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_vec++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
      end
   endtask

   // rate tick generator
   int tick_div = 3;
   int tcnt = 0;
   initial begin
      forever begin
         @(negedge clk);
         tcnt++;
         rate_tick = ((tcnt % tick_div) == 0);
      end
   end

   // what the design saw at each edge
   logic s_tick, s_up, s_down, s_wr;
   logic [7:0] s_addr, s_data;
   always @(posedge clk) begin
      s_tick <= rate_tick; s_up <= req_power_up; s_down <= req_power_down;
      s_wr <= req_write; s_addr <= wr_addr; s_data <= wr_data;
   end

   // reference model
   int    exp_q[$];
   string tag_q[$];
   bit    model_busy, due, exp_done, old_busy, gap_active, last_job_frame;
   int    gap_cnt, hi_ticks, nbits;
   logic  [15:0] cap;
   logic  p_sel, p_clk, p_dat;

   always @(negedge clk) begin
      if (!rst_n) begin
         model_busy = 0; due = 0; gap_active = 0; gap_cnt = 0;
         hi_ticks = 100; nbits = 0; cap = '0; last_job_frame = 0;
         p_sel = 1'b1; p_clk = 1'b1; p_dat = 1'b0;
      end else begin
         exp_done = due; due = 0;
         old_busy = model_busy;
         if (exp_done) model_busy = 0;
         if (!old_busy && (s_up || s_down || s_wr)) begin
            model_busy = 1;
            if (s_up) begin // R11 power-up first
               exp_q.push_back(16'h051E); tag_q.push_back("R5");
               exp_q.push_back(16'h055E); tag_q.push_back("R5");
               exp_q.push_back(16'h078D); tag_q.push_back("R5");
               exp_q.push_back(16'h1301); tag_q.push_back("R5");
               exp_q.push_back(16'h055F); tag_q.push_back("R5");
            end else if (s_down) begin
               exp_q.push_back(16'h055E); tag_q.push_back("R6");
            end else begin
               exp_q.push_back({16'h0, s_addr, s_data}); tag_q.push_back("R7");
            end
         end
         chk(done === exp_done, "R10 done", done, exp_done);
         chk(busy === model_busy, "R9 busy", busy, model_busy);
         if ({ser_sel_n, ser_clk, ser_dat} != {p_sel, p_clk, p_dat})
            chk(s_tick, "R8 change without tick", 0, 1);
         if (!old_busy && !gap_active)
            chk(ser_sel_n && ser_clk && !ser_dat, "R2 idle lines",
                {ser_sel_n, ser_clk, ser_dat}, 3'b110);
         if (p_sel && ser_sel_n && s_tick) hi_ticks++;
         if (p_sel && !ser_sel_n) begin
            chk(p_clk && ser_clk && !ser_dat, "R2 select fall", {ser_clk, ser_dat}, 2'b10);
            chk(hi_ticks >= GAP, "R8 select gap", hi_ticks, GAP);
            nbits = 0;
         end
         if (!p_clk && ser_clk && !ser_sel_n) begin
            cap = {cap[14:0], ser_dat};
            nbits++;
         end
         if (p_clk && ser_clk && !p_sel && !ser_sel_n && (ser_dat != p_dat))
            chk(0, "R3 data moved while clock high", ser_dat, p_dat);
         if (gap_active && p_sel && ser_sel_n && s_tick) begin
            gap_cnt++;
            if (gap_cnt == GAP) begin
               gap_active = 0;
               if (last_job_frame) due = 1;
            end
         end
         if (!p_sel && ser_sel_n) begin
            hi_ticks = 0;
            chk(nbits == 16 && ser_clk, "R4 frame end", nbits, 16);
            if (exp_q.size() == 0) begin
               chk(0, "R9 unexpected frame", cap, 0);
               last_job_frame = 0;
            end else begin
               int e;
               string t;
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               chk(cap == e[15:0], {t, " R1 frame content"}, cap, e);
               last_job_frame = (exp_q.size() == 0);
            end
            gap_active = 1; gap_cnt = 0;
         end
         p_sel = ser_sel_n; p_clk = ser_clk; p_dat = ser_dat;
      end
   end

   task automatic report();
      if (!finished) begin
         finished = 1;
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   endtask

   task automatic request(input bit up, input bit down, input bit wr,
                          input logic [7:0] a, input logic [7:0] d);
      req_power_up = up; req_power_down = down; req_write = wr;
      wr_addr = a; wr_data = d;
      @(negedge clk);
      req_power_up = 0; req_power_down = 0; req_write = 0;
   endtask

   task automatic wait_done();
      for (int i = 0; i < 20000; i++) begin
         @(negedge clk);
         if (done) break;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected finish");
      report();
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R12 reset state
      chk({ser_sel_n, ser_clk, ser_dat, busy, done} == 5'b11000, "R12 reset state",
          {ser_sel_n, ser_clk, ser_dat, busy, done}, 5'b11000);

      // R5 power-up list, with R9 ignored requests mid-job
      request(1, 0, 0, 8'h00, 8'h00);
      repeat (30) @(negedge clk);
      request(0, 1, 0, 8'h00, 8'h00);
      repeat (7) @(negedge clk);
      request(0, 0, 1, 8'h3C, 8'hC3);
      wait_done();
      // request in the very cycle done is high: accepted (R7, R10)
      request(0, 0, 1, 8'h21, 8'hA7);
      wait_done();

      tick_div = 1;
      request(0, 1, 0, 8'h00, 8'h00);        // R6
      wait_done();
      request(1, 1, 1, 8'h11, 8'h22);        // R11 power-up wins
      repeat (50) @(negedge clk);
      request(1, 0, 0, 8'h00, 8'h00);        // R9 ignored
      wait_done();
      request(0, 1, 1, 8'h33, 8'h44);        // R11 power-down beats write
      wait_done();

      tick_div = 2;
      request(0, 0, 1, 8'hFF, 8'h00);        // R1 boundary patterns
      wait_done();
      request(0, 0, 1, 8'h00, 8'hFF);
      wait_done();
      request(0, 0, 1, 8'hAA, 8'h55);
      wait_done();
      repeat (40) @(negedge clk);
      chk(exp_q.size() == 0, "R9 frames missing", exp_q.size(), 0);
      report();
   end

endmodule